// File: doc/BRIEF.md
# Receive/Transmit Byte Queues with Interrupt Identification

This block sits behind the register decoder of a serial port. It owns two byte queues of equal depth: one collects bytes arriving from the line side, the other holds bytes that software has written for sending. Each queue keeps a write pointer, a read pointer and a full flag, and reports its occupancy every cycle. The oldest byte of each queue is always presented on a data output, and a pop strobe removes it.

A small interrupt identifier watches the two occupancies. When the receive occupancy reaches a programmable threshold, or when the transmit queue has room, it loads an identification code and drives a level interrupt. The receive source wins over the transmit source. The identification byte also carries a no-interrupt-pending flag and, in its top two bits, the queue-enable state. The block also produces the receive data-ready and overrun flags and the transmit-empty flags that a line status register shows.

Top module: `uart_dual_queue_irq`

## Requirements
- R1: After reset both occupancies are 0, the identification byte reads 0x01 (no ID, pending flag 1), the interrupt is low, data-ready and overrun are 0, and both transmit-empty flags are 1.
- R2: Each queue returns bytes in the order they were pushed. The head byte is visible on its data output while the queue is non-empty. The occupancy counts pushes minus pops and never exceeds the depth of 16.
- R3: A receive push while the receive queue is full, with no pop in the same cycle, drops the byte and sets overrun. A status-read strobe clears overrun. A transmit push to a full transmit queue drops the byte.
- R4: A pop from an empty queue leaves occupancy, contents and flags unchanged.
- R5: A push and a pop in the same cycle on a non-empty queue keep the occupancy unchanged, including when the queue is full. The popped byte is the oldest one and the pushed byte joins the tail.
- R6: A flush strobe empties its own queue in one cycle, whatever push or pop arrives with it, and leaves the other queue untouched.
- R7: The receive threshold select uses 0 = 1 byte, 1 = 4 bytes, 2 = 8 bytes and 3 = 14 bytes. One cycle after the receive interrupt is enabled and the receive occupancy is at or above the threshold, ID bits 3:1 read 2, bit 0 reads 0 and the interrupt is high.
- R8: Once the receive occupancy is below the threshold (and the transmit source is idle), the ID returns to 0 and the pending bit to 1 one cycle later.
- R9: With the transmit interrupt enabled, ID 1 with pending 0 and a high interrupt appear one cycle after the transmit queue is not full. When it becomes full, ID 0 and pending 1 follow one cycle later.
- R10: When both sources are active, the receive ID 2 is reported.
- R11: Identification bits 7:6 read 11 when the queue-enable input is 1 and 00 otherwise. Bits 5:4 always read 0.
- R12: Data-ready is 1 exactly when the receive queue is non-empty. Both transmit-empty flags are 0 after a transmit push and return to 1 when the transmit queue drains or is flushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_irq_en_i | input | 1 | Enable receive threshold interrupt |
| tx_irq_en_i | input | 1 | Enable transmit room interrupt |
| rx_trig_sel_i | input | 2 | Receive threshold select |
| fifo_en_i | input | 1 | Queue-enable state, mirrored in ID bits 7:6 |
| rx_push_i | input | 1 | Push strobe for the receive queue |
| rx_push_data_i | input | 8 | Byte to push into the receive queue |
| rx_pop_i | input | 1 | Pop strobe for the receive queue |
| rx_flush_i | input | 1 | Empty the receive queue |
| tx_push_i | input | 1 | Push strobe for the transmit queue |
| tx_push_data_i | input | 8 | Byte to push into the transmit queue |
| tx_pop_i | input | 1 | Pop strobe for the transmit queue |
| tx_flush_i | input | 1 | Empty the transmit queue |
| stat_rd_i | input | 1 | Status read strobe, clears overrun |
| rx_pop_data_o | output | 8 | Oldest receive byte (0 when empty) |
| tx_pop_data_o | output | 8 | Oldest transmit byte (0 when empty) |
| rx_count_o | output | 5 | Receive occupancy |
| tx_count_o | output | 5 | Transmit occupancy |
| iir_o | output | 8 | Interrupt identification byte |
| irq_o | output | 1 | Level interrupt request |
| data_ready_o | output | 1 | Receive data available |
| overrun_o | output | 1 | Receive byte dropped since last status read |
| thr_empty_o | output | 1 | Transmit holding side empty |
| tx_empty_o | output | 1 | Transmitter empty |

## Verification
The assertions rely on every strobe being a clean 0 or 1 from the first clock after reset, and on the threshold select and enables staying fixed for the cycle that follows each condition they watch. The stimulus drives every input one time unit after a rising edge and changes the threshold and the enables only while the queues sit idle. The stimulus pushes and pops through a scoreboard of expected bytes. It then waits one idle cycle before it compares the registered identification byte, so each property's window closes on stable inputs.

// File: rtl/uart_q_pkg.sv
package uart_q_pkg;

  typedef enum logic [2:0] {
    IID_NONE     = 3'd0,
    IID_TX_ROOM  = 3'd1,
    IID_RX_LEVEL = 3'd2
  } iid_e;

  // receive threshold in bytes for a 2-bit select
  function automatic int unsigned rx_trig_bytes(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/byte_queue.sv
module byte_queue #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pop_i,
  output logic [DW-1:0] pop_data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q, wr_nx, rd_nx;
  logic          full_q;
  logic          pop_ok, push_ok;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = !full_q && (wr_q == rd_q);
  assign full_o  = full_q;
  assign pop_ok  = pop_i && !empty_o && !flush_i;
  assign push_ok = push_i && !flush_i && (!full_q || pop_ok);
  assign wr_nx   = ptr_inc(wr_q);
  assign rd_nx   = ptr_inc(rd_q);

  always_comb begin
    if (full_q)          count_o = CW'(DEPTH);
    else if (wr_q >= rd_q) count_o = CW'(wr_q) - CW'(rd_q);
    else                 count_o = CW'(DEPTH) + CW'(wr_q) - CW'(rd_q);
  end

  assign pop_data_o = empty_o ? '0 : mem_q[rd_q];

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= push_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      full_q <= 1'b0;
    end else if (flush_i) begin
      wr_q   <= '0;
      rd_q   <= '0;
      full_q <= 1'b0;
    end else begin
      if (push_ok) wr_q <= wr_nx;
      if (pop_ok)  rd_q <= rd_nx;
      if (push_ok && !pop_ok && (wr_nx == rd_q)) full_q <= 1'b1;
      else if (pop_ok && !push_ok)               full_q <= 1'b0;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH)); // R2
  AST_FULL_PUSH_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !flush_i |=> full_o && $stable(wr_q)); // R3
  AST_EMPTY_POP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && pop_i && !push_i && !flush_i |=> empty_o && $stable(rd_q)); // R4
  AST_PUSH_POP_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_o && push_i && pop_i && !flush_i |=> $stable(count_o)); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o); // R6

endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
  import uart_q_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_irq_en_i,
  input  logic          tx_irq_en_i,
  input  logic [1:0]    rx_trig_sel_i,
  input  logic          fifo_en_i,
  input  logic [CW-1:0] rx_count_i,
  input  logic          tx_full_i,
  output logic [7:0]    iir_o,
  output logic          irq_o
);

  iid_e iid_q, iid_d;
  logic pend_q, pend_d;
  logic rx_hit, tx_hit;

  assign rx_hit = rx_irq_en_i && (int'(rx_count_i) >= int'(rx_trig_bytes(rx_trig_sel_i)));
  assign tx_hit = tx_irq_en_i && !tx_full_i;

  // receive source outranks transmit source
  always_comb begin
    if (rx_hit) begin
      iid_d  = IID_RX_LEVEL;
      pend_d = 1'b0;
    end else if (tx_hit) begin
      iid_d  = IID_TX_ROOM;
      pend_d = 1'b0;
    end else begin
      iid_d  = IID_NONE;
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iid_q  <= IID_NONE;
      pend_q <= 1'b1;
    end else begin
      iid_q  <= iid_d;
      pend_q <= pend_d;
    end
  end

  assign iir_o = {{2{fifo_en_i}}, 2'b00, iid_q, pend_q};
  assign irq_o = !pend_q;

  AST_RX_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_en_i && tx_irq_en_i && !tx_full_i && (rx_count_i >= CW'(14))
    |=> iir_o[3:1] == 3'd2 && irq_o); // R10
  AST_TX_FULL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_irq_en_i && tx_full_i |=> !irq_o && iir_o[0]); // R9
  AST_RX_EMPTY_NO_RX_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_count_i == '0 |=> iir_o[3:1] != 3'd2); // R8

endmodule

// File: rtl/uart_dual_queue_irq.sv
module uart_dual_queue_irq
  import uart_q_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_irq_en_i,
  input  logic          tx_irq_en_i,
  input  logic [1:0]    rx_trig_sel_i,
  input  logic          fifo_en_i,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_push_data_i,
  input  logic          rx_pop_i,
  input  logic          rx_flush_i,
  input  logic          tx_push_i,
  input  logic [DW-1:0] tx_push_data_i,
  input  logic          tx_pop_i,
  input  logic          tx_flush_i,
  input  logic          stat_rd_i,
  output logic [DW-1:0] rx_pop_data_o,
  output logic [DW-1:0] tx_pop_data_o,
  output logic [CW-1:0] rx_count_o,
  output logic [CW-1:0] tx_count_o,
  output logic [7:0]    iir_o,
  output logic          irq_o,
  output logic          data_ready_o,
  output logic          overrun_o,
  output logic          thr_empty_o,
  output logic          tx_empty_o
);

  localparam int unsigned NQ = 2; // 0: receive, 1: transmit

  logic [NQ-1:0]         q_flush, q_push, q_pop, q_full, q_empty;
  logic [NQ-1:0][DW-1:0] q_wdata, q_rdata;
  logic [NQ-1:0][CW-1:0] q_count;
  logic                  rx_drop;
  logic                  ovr_q;

  assign q_flush = {tx_flush_i, rx_flush_i};
  assign q_push  = {tx_push_i, rx_push_i};
  assign q_pop   = {tx_pop_i, rx_pop_i};
  assign q_wdata = {tx_push_data_i, rx_push_data_i};

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    byte_queue #(.DW(DW), .DEPTH(DEPTH)) i_queue (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .flush_i     (q_flush[q]),
      .push_i      (q_push[q]),
      .push_data_i (q_wdata[q]),
      .pop_i       (q_pop[q]),
      .pop_data_o  (q_rdata[q]),
      .count_o     (q_count[q]),
      .full_o      (q_full[q]),
      .empty_o     (q_empty[q])
    );
  end

  uart_irq_id #(.CW(CW)) i_irq_id (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rx_irq_en_i   (rx_irq_en_i),
    .tx_irq_en_i   (tx_irq_en_i),
    .rx_trig_sel_i (rx_trig_sel_i),
    .fifo_en_i     (fifo_en_i),
    .rx_count_i    (q_count[0]),
    .tx_full_i     (q_full[1]),
    .iir_o         (iir_o),
    .irq_o         (irq_o)
  );

  // a push into a full receive queue with no pop to make room is lost
  assign rx_drop = rx_push_i && !rx_flush_i && q_full[0] && !rx_pop_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_q <= 1'b0;
    else if (rx_drop)   ovr_q <= 1'b1;
    else if (stat_rd_i) ovr_q <= 1'b0;
  end

  assign rx_pop_data_o = q_rdata[0];
  assign tx_pop_data_o = q_rdata[1];
  assign rx_count_o    = q_count[0];
  assign tx_count_o    = q_count[1];
  assign data_ready_o  = !q_empty[0];
  assign overrun_o     = ovr_q;
  assign thr_empty_o   = q_empty[1];
  assign tx_empty_o    = q_empty[1];

  AST_OVERRUN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i && (rx_count_o == CW'(DEPTH)) && !rx_pop_i && !rx_flush_i
    |=> overrun_o && (rx_count_o == CW'(DEPTH))); // R3
  AST_OVERRUN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i && !rx_push_i |=> !overrun_o); // R3
  AST_TX_PUSH_NOT_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push_i && !tx_flush_i |=> !thr_empty_o && !tx_empty_o); // R12

endmodule

// File: tb/test_uart_dual_queue_irq.sv
module test_uart_dual_queue_irq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_irq_en = 0, tx_irq_en = 0, fifo_en = 0;
  logic [1:0] trig_sel = 0;
  logic       rx_push = 0, rx_pop = 0, rx_flush = 0;
  logic       tx_push = 0, tx_pop = 0, tx_flush = 0, stat_rd = 0;
  logic [7:0] rx_wd = 0, tx_wd = 0;
  logic [7:0] rx_rd, tx_rd, iir;
  logic [4:0] rx_cnt, tx_cnt;
  logic       irq, dr, ovr, thre, temt;

  int n_checks = 0, n_errors = 0;
  logic [7:0] rx_q[$];
  logic [7:0] tx_q[$];
  bit exp_ovr = 0;

  always #10 clk = ~clk; // 50 MHz

  uart_dual_queue_irq i_uart_dual_queue_irq (
    .clk_i(clk), .rst_ni(rst_n),
    .rx_irq_en_i(rx_irq_en), .tx_irq_en_i(tx_irq_en),
    .rx_trig_sel_i(trig_sel), .fifo_en_i(fifo_en),
    .rx_push_i(rx_push), .rx_push_data_i(rx_wd), .rx_pop_i(rx_pop), .rx_flush_i(rx_flush),
    .tx_push_i(tx_push), .tx_push_data_i(tx_wd), .tx_pop_i(tx_pop), .tx_flush_i(tx_flush),
    .stat_rd_i(stat_rd),
    .rx_pop_data_o(rx_rd), .tx_pop_data_o(tx_rd),
    .rx_count_o(rx_cnt), .tx_count_o(tx_cnt),
    .iir_o(iir), .irq_o(irq), .data_ready_o(dr), .overrun_o(ovr),
    .thr_empty_o(thre), .tx_empty_o(temt)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int trig_of(input logic [1:0] s);
    case (s) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  function automatic int exp_iir();
    int id;
    if (rx_irq_en && rx_q.size() >= trig_of(trig_sel)) id = 2;
    else if (tx_irq_en && tx_q.size() < 16)             id = 1;
    else                                                id = 0;
    return (fifo_en ? 8'hC0 : 8'h00) | (id << 1) | ((id == 0) ? 1 : 0);
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // scoreboard monitor: compare head byte with the oldest expected one
  task automatic mon_rx(input string req);
    if (rx_q.size() > 0) begin chk(req, rx_rd, rx_q[0]); void'(rx_q.pop_front()); end
  endtask
  task automatic mon_tx(input string req);
    if (tx_q.size() > 0) begin chk(req, tx_rd, tx_q[0]); void'(tx_q.pop_front()); end
  endtask

  task automatic drv_rx_push(input logic [7:0] d);
    rx_push = 1; rx_wd = d;
    if (rx_q.size() < 16) rx_q.push_back(d); else exp_ovr = 1;
    tick(); rx_push = 0;
  endtask
  task automatic drv_rx_pop();
    rx_pop = 1; mon_rx("R2"); tick(); rx_pop = 0;
  endtask
  task automatic drv_rx_both(input logic [7:0] d);
    rx_push = 1; rx_pop = 1; rx_wd = d;
    mon_rx("R5"); rx_q.push_back(d);
    tick(); rx_push = 0; rx_pop = 0;
  endtask
  task automatic drv_tx_push(input logic [7:0] d);
    tx_push = 1; tx_wd = d;
    if (tx_q.size() < 16) tx_q.push_back(d);
    tick(); tx_push = 0;
  endtask
  task automatic drv_tx_pop();
    tx_pop = 1; mon_tx("R2"); tick(); tx_pop = 0;
  endtask
  task automatic drv_rx_flush();
    rx_flush = 1; rx_q.delete(); tick(); rx_flush = 0;
  endtask
  task automatic drv_tx_flush();
    tx_flush = 1; tx_q.delete(); tick(); tx_flush = 0;
  endtask

  task automatic chk_iir(input string req);
    tick();
    chk(req, iir, exp_iir());
    chk(req, irq, (exp_iir() & 1) ? 0 : 1);
  endtask

  initial begin
    #2_000_000;
    n_errors++; n_checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    // R1 reset state
    chk("R1", rx_cnt, 0); chk("R1", tx_cnt, 0); chk("R1", iir, 8'h01);
    chk("R1", irq, 0); chk("R1", dr, 0); chk("R1", ovr, 0);
    chk("R1", thre, 1); chk("R1", temt, 1);

    // R2 order and counts
    for (int i = 0; i < 5; i++) drv_rx_push(8'h10 + 8'(i));
    chk("R2", rx_cnt, 5); chk("R12", dr, 1);
    drv_rx_pop(); drv_rx_pop();
    chk("R2", rx_cnt, 3);

    // R3 overrun on full receive queue
    for (int i = 0; i < 14; i++) drv_rx_push(8'h40 + 8'(i));
    chk("R2", rx_cnt, 16); chk("R3", ovr, exp_ovr);
    chk("R3", ovr, 1);
    stat_rd = 1; tick(); stat_rd = 0; exp_ovr = 0;
    chk("R3", ovr, 0);

    // R5 push+pop on full queue
    drv_rx_both(8'hA5); chk("R5", rx_cnt, 16); chk("R5", ovr, 0);
    drv_rx_both(8'h5A); chk("R5", rx_cnt, 16);

    // drain, R12 data-ready, R4 pop on empty
    while (rx_q.size() > 0) drv_rx_pop();
    chk("R12", dr, 0); chk("R2", rx_cnt, 0);
    rx_pop = 1; tick(); rx_pop = 0;
    chk("R4", rx_cnt, 0); chk("R4", dr, 0); chk("R4", rx_rd, 0);
    drv_rx_push(8'h77); chk("R4", rx_rd, 8'h77);
    drv_rx_both(8'h78); chk("R5", rx_cnt, 1); chk("R5", rx_rd, 8'h78);

    // R6 flush with a push in the same cycle
    drv_tx_push(8'h33);
    rx_push = 1; rx_wd = 8'h99; rx_flush = 1; rx_q.delete();
    tick(); rx_push = 0; rx_flush = 0;
    chk("R6", rx_cnt, 0); chk("R6", tx_cnt, 1); chk("R6", tx_rd, 8'h33);
    drv_tx_flush(); chk("R6", tx_cnt, 0); chk("R12", thre, 1); chk("R12", temt, 1);

    // R7/R8 every threshold encoding
    rx_irq_en = 1;
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      drv_rx_flush();
      for (int i = 0; i < trig_of(2'(s)) - 1; i++) drv_rx_push(8'(i));
      chk_iir("R7");
      drv_rx_push(8'hE0 + 8'(s));
      chk_iir("R7"); chk("R7", iir, 8'h04);
      drv_rx_pop();
      chk_iir("R8"); chk("R8", iir, 8'h01);
    end
    drv_rx_flush();

    // R9 transmit room interrupt and R12 empty flags
    rx_irq_en = 0; tx_irq_en = 1;
    chk_iir("R9"); chk("R9", iir, 8'h02);
    drv_tx_push(8'hC1); chk("R12", thre, 0); chk("R12", temt, 0);
    for (int i = 0; i < 15; i++) drv_tx_push(8'hC2 + 8'(i));
    chk("R2", tx_cnt, 16);
    chk_iir("R9"); chk("R9", iir, 8'h01);
    drv_tx_push(8'hFF); chk("R3", tx_cnt, 16);
    drv_tx_pop(); chk_iir("R9"); chk("R9", iir, 8'h02);
    while (tx_q.size() > 0) drv_tx_pop();
    chk("R12", thre, 1); chk("R12", temt, 1);

    // R10 priority, R11 enable mirror
    rx_irq_en = 1; trig_sel = 2'd0; fifo_en = 1;
    drv_rx_push(8'h55);
    chk_iir("R10"); chk("R10", iir, 8'hC4);
    drv_rx_pop();
    chk_iir("R11"); chk("R11", iir, 8'hC2);
    fifo_en = 0; tick(); chk("R11", iir, 8'h02);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule